// File: doc/BRIEF.md
# Capability Revocation Epoch Filter

This block sits on the return path of capability loads, between the memory system and the register file. Every capability arriving from memory is tagged with the epoch in which it was minted. When the load asks for barrier treatment, the block compares that tag with a privileged epoch register. A capability minted in an earlier epoch is swapped for an invalidated value before it leaves the block. This lets software revoke every outstanding capability at once by advancing a single register, without walking memory for each released object.

Input and output are valid/ready streams with one register stage between them. The replacement is either all zeros or a fixed sentinel pattern, chosen by a configuration input. A write port loads the epoch register and a read-out port reflects it. Epoch comparison uses serial-number arithmetic over an 8-bit space, so the counter may wrap freely.

Top module: `cap_epoch_barrier`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0, `cur_epoch` is 0 and `in_ready` is 1.
- R2: A cycle with `ep_wr_en` high loads `ep_wr_data` into the epoch register, visible on `cur_epoch` from the next cycle. Without a write, the register keeps its value.
- R3: An accepted load with `in_barrier` low is delivered with `out_cap` equal to `in_cap`, whatever its creation epoch.
- R4: An accepted load with `in_barrier` high is delivered unchanged when its creation epoch equals the current epoch or is newer than it. Let d = (current − creation) mod 256. The load is newer when d is 0 or at least 128.
- R5: An accepted load with `in_barrier` high whose d lies in 1..127 is stale, and its payload is replaced.
- R6: The replacement is all zeros when `cfg_sentinel` is 0. When `cfg_sentinel` is 1 it is the sentinel: the upper half of the word is zero and the lower half is all ones. `cfg_sentinel` is sampled in the cycle the load is accepted.
- R7: Staleness is decided modulo 256 across wraparound. With current 2 and creation 250, the load is revoked. With current 250, creation 2 passes, creation 122 (d = 128) passes, and creation 123 (d = 127) is revoked.
- R8: A barrier load accepted in the same cycle as an epoch write is judged against the old epoch. The new epoch applies from the next accepted load onward.
- R9: `in_ready` equals `!out_valid || out_ready`. An accepted load appears on the output in the next cycle. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_cap` holds its value. Outputs leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Loaded capability is present |
| in_ready | output | 1 | Block can take a capability this cycle |
| in_cap | input | 128 | Loaded capability word |
| in_epoch | input | 8 | Epoch in which the capability was created |
| in_barrier | input | 1 | Apply the epoch check to this load |
| out_valid | output | 1 | Filtered capability is present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_cap | output | 128 | Capability word, or its invalidated replacement |
| cfg_sentinel | input | 1 | 0: clear stale capabilities to zero; 1: use the sentinel |
| ep_wr_en | input | 1 | Write the epoch register |
| ep_wr_data | input | 8 | New epoch value |
| cur_epoch | output | 8 | Current epoch register value |

## Verification
Several properties are checked on every cycle:
- output stability under back-pressure;
- the fill that follows an acceptance;
- the epoch register's load-and-hold behaviour;
- unchanged delivery for loads without the barrier, and for barrier loads whose creation epoch matches the current one.

Other behaviours can only be shown by the bench's scenarios: the serial-arithmetic boundaries at distances 127 and 128, the wrap across zero, the choice between zero and sentinel, and the use of the old epoch for a load that coincides with a write. The bench tracks the epoch it has written and predicts each output in a scoreboard. It also drives a randomized stream under random stalls.

// File: rtl/cap_epoch_barrier.sv
module cap_epoch_barrier #(
  parameter int CAP_W   = 128,
  parameter int EPOCH_W = 8,
  parameter logic [CAP_W-1:0] REVOKED_VALUE = {{(CAP_W/2){1'b0}}, {(CAP_W/2){1'b1}}}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CAP_W-1:0]   in_cap,
  input  logic [EPOCH_W-1:0] in_epoch,
  input  logic               in_barrier,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CAP_W-1:0]   out_cap,
  input  logic               cfg_sentinel,
  input  logic               ep_wr_en,
  input  logic [EPOCH_W-1:0] ep_wr_data,
  output logic [EPOCH_W-1:0] cur_epoch
);

  logic [EPOCH_W-1:0] epoch_q;
  logic [EPOCH_W-1:0] age;
  logic               stale;
  logic               take;
  logic [CAP_W-1:0]   filtered;

  assign age      = epoch_q - in_epoch;
  assign stale    = in_barrier && (age != '0) && !age[EPOCH_W-1];
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign filtered = stale ? (cfg_sentinel ? REVOKED_VALUE : '0) : in_cap;
  assign cur_epoch = epoch_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        epoch_q <= '0;
    else if (ep_wr_en) epoch_q <= ep_wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cap   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_cap   <= filtered;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid && cur_epoch == '0); // R1
  AST_EPOCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ep_wr_en |=> cur_epoch == $past(ep_wr_data)); // R2
  AST_EPOCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_wr_en |=> $stable(cur_epoch)); // R2
  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_barrier |=> out_cap == $past(in_cap)); // R3
  AST_SAME_EPOCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_barrier && in_epoch == cur_epoch |=> out_cap == $past(in_cap)); // R4
  AST_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cap)); // R9

endmodule

// File: tb/cap_epoch_barrier_tb.sv
`timescale 1ns/100ps
module cap_epoch_barrier_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_cap = '0;
  logic [7:0]   in_epoch = '0;
  logic         in_barrier = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_cap;
  logic         cfg_sentinel = 1'b0;
  logic         ep_wr_en = 1'b0;
  logic [7:0]   ep_wr_data = '0;
  logic [7:0]   cur_epoch;

  localparam logic [127:0] SENT = {64'h0, {64{1'b1}}};

  int checks = 0;
  int failures = 0;
  logic [7:0] model_epoch = 8'd0;
  logic [127:0] exp_q[$];
  string tag_q[$];
  bit stall_en = 1'b0;
  bit prev_stall = 1'b0;
  logic [127:0] held_cap;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cap_epoch_barrier u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cap(in_cap), .in_epoch(in_epoch), .in_barrier(in_barrier),
    .out_valid(out_valid), .out_ready(out_ready), .out_cap(out_cap),
    .cfg_sentinel(cfg_sentinel), .ep_wr_en(ep_wr_en), .ep_wr_data(ep_wr_data),
    .cur_epoch(cur_epoch)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] predict(input logic [127:0] c, input logic [7:0] ce,
                                           input bit bar, input bit sent, input logic [7:0] cur);
    logic [7:0] d;
    d = cur - ce;
    if (bar && d >= 8'd1 && d <= 8'd127) return sent ? SENT : 128'h0;
    return c;
  endfunction

  task automatic send(input logic [127:0] c, input logic [7:0] ce, input bit bar,
                      input bit sent, input string tag, input bit wr = 0, input logic [7:0] wd = 0);
    @(posedge clk); #1;
    in_valid = 1'b1; in_cap = c; in_epoch = ce; in_barrier = bar; cfg_sentinel = sent;
    ep_wr_en = wr; ep_wr_data = wd;
    @(negedge clk);
    while (!in_ready) begin
      ep_wr_en = 1'b0;
      @(negedge clk);
    end
    exp_q.push_back(predict(c, ce, bar, sent, model_epoch));
    tag_q.push_back(tag);
    if (ep_wr_en) model_epoch = wd;
    @(posedge clk); #1;
    in_valid = 1'b0; ep_wr_en = 1'b0;
  endtask

  task automatic write_epoch(input logic [7:0] v);
    @(posedge clk); #1;
    ep_wr_en = 1'b1; ep_wr_data = v;
    @(posedge clk); #1;
    ep_wr_en = 1'b0;
    model_epoch = v;
    @(negedge clk);
    check(cur_epoch == v, "R2 epoch write", {120'h0, cur_epoch}, {120'h0, v});
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (stall_en) out_ready = ($urandom % 3) != 0;
    else out_ready = 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_cap == held_cap, "R9 hold under stall", out_cap, held_cap);
      prev_stall = out_valid && !out_ready;
      held_cap = out_cap;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected output", out_cap, 128'h0);
        end else begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_cap == e, t, out_cap, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 out_valid after reset", {127'h0, out_valid}, 128'h0);
    check(cur_epoch == 8'd0, "R1 epoch after reset", {120'h0, cur_epoch}, 128'h0);
    check(in_ready, "R1 in_ready after reset", {127'h0, in_ready}, 128'h1);

    write_epoch(8'd10);
    repeat (2) @(negedge clk);
    check(cur_epoch == 8'd10, "R2 epoch holds", {120'h0, cur_epoch}, 128'd10);

    send(128'hA5A5_0001, 8'd3, 1'b0, 1'b0, "R3 plain load passes");
    send(128'hA5A5_0002, 8'd10, 1'b1, 1'b0, "R4 equal epoch passes");
    send(128'hA5A5_0003, 8'd12, 1'b1, 1'b0, "R4 newer epoch passes");
    send(128'hA5A5_0004, 8'd9, 1'b1, 1'b0, "R5 R6 stale cleared to zero");
    send(128'hA5A5_0005, 8'd9, 1'b1, 1'b1, "R5 R6 stale to sentinel");
    drain();

    write_epoch(8'd2);
    send(128'hB000_0001, 8'd250, 1'b1, 1'b0, "R7 wrap stale revoked");
    write_epoch(8'd250);
    send(128'hB000_0002, 8'd2, 1'b1, 1'b0, "R7 wrap newer passes");
    send(128'hB000_0003, 8'd122, 1'b1, 1'b1, "R7 distance 128 passes");
    send(128'hB000_0004, 8'd123, 1'b1, 1'b1, "R7 distance 127 revoked");
    drain();

    send(128'hC000_0001, 8'd250, 1'b1, 1'b0, "R8 same-cycle write uses old epoch", 1'b1, 8'd5);
    send(128'hC000_0002, 8'd250, 1'b1, 1'b0, "R8 next load uses new epoch");
    drain();
    check(cur_epoch == 8'd5, "R8 epoch after same-cycle write", {120'h0, cur_epoch}, 128'd5);

    stall_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      send({$urandom, $urandom, $urandom, $urandom}, 8'($urandom), 1'($urandom),
           1'($urandom), "R9 stream under stalls");
    end
    drain();
    stall_en = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule